// File: doc/BRIEF.md
# Pipeline Abort Exception Controller

This block tracks memory aborts through a small three-stage core model: fetch, decode and execute. An instruction fetch that returns with an abort does not trap straight away. The fetched slot carries an abort tag into decode and then into execute, and the exception is raised only when that slot reaches execute. If a taken branch flushes the slot before then, no exception occurs.

Data accesses are issued by the instruction in execute, and the response arrives one cycle later. The block holds that instruction in a memory-response slot. A data abort on the response cancels the access's side effects at once: both the addressing-mode base writeback and the register write of loaded data are dropped. This leaves the base register as it was before the instruction, so the handler never has to unwind it.

For either abort the block produces the entry outputs: a redirect to a fixed vector, the saved return address, the saved copy of the status word and the new status word (abort mode, IRQs masked). It also flushes all younger pipeline slots.

Top module: `abt_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, no slot is occupied. The outputs exc_kind, redirect_valid, base_wb_cancel, load_we_cancel and ex_live are all zero.
- R2: A fetch with fetch_valid and fetch_iabort high becomes a tagged slot. Two cycles later, if the slot has not been flushed, exc_kind is 1 (instruction abort). The tagged slot never asserts ex_live.
- R3: A live execute instruction with ex_branch_taken high discards the decode slot and the same-cycle fetch. A tagged slot discarded this way never raises an abort. While a tagged slot is in execute, ex_branch_taken has no effect.
- R4: mem_dabort is sampled only in the cycle after a live execute instruction had ex_mem_op high, for loads and stores alike. The data abort then sets exc_kind to 2, base_wb_cancel to 1 and load_we_cancel to the access's ex_is_load value. At any other time mem_dabort is ignored.
- R5: When a data abort and a tagged slot in execute coincide, the data abort is taken. The tagged slot is flushed and raises nothing.
- R6: Any abort flushes execute, decode and the same-cycle fetch. It sets redirect_valid, and redirect_pc is 0x0C for an instruction abort and 0x10 for a data abort.
- R7: lr_abt is the faulting instruction's address plus 4 for an instruction abort and plus 8 for a data abort.
- R8: On an abort, spsr_abt equals status_in. status_next equals status_in with bits [4:0] set to 5'b10111 (abort mode) and bit 7 (IRQ disable) set, and all other bits unchanged.
- R9: In a cycle with no abort, exc_kind is 0 and redirect_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch completes this cycle |
| fetch_pc | input | AW | Address of the fetched instruction |
| fetch_iabort | input | 1 | Fetch returned an abort |
| ex_mem_op | input | 1 | Execute instruction issues a data access |
| ex_is_load | input | 1 | That data access is a load |
| ex_branch_taken | input | 1 | Execute instruction is a taken branch |
| mem_dabort | input | 1 | Pending data access returned an abort |
| status_in | input | SW | Current status word |
| ex_live | output | 1 | A valid, untagged instruction executes this cycle |
| ex_pc | output | AW | Address of the execute slot |
| exc_kind | output | 2 | 0 none, 1 instruction abort, 2 data abort |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | AW | Abort vector |
| lr_abt | output | AW | Saved return address |
| spsr_abt | output | SW | Saved status word |
| status_next | output | SW | Status word on abort entry |
| base_wb_cancel | output | 1 | Suppress base register writeback |
| load_we_cancel | output | 1 | Suppress register write of load data |

## Verification
The bench builds the block with a 32-bit address, an 8-bit status word and the IRQ-disable flag at bit 7. It uses the default vectors, so the return-address offsets and the status rewrite can be checked against exact values. Random sequences drive fetch aborts, taken branches and data aborts often enough to produce flushed tagged slots and aborts in consecutive cycles. Directed sequences set up a data abort that coincides with a tagged slot in execute, and a data abort with no access pending.

// File: rtl/abt_pkg.sv
`timescale 1ns/1ps
package abt_pkg;
    typedef enum logic [1:0] {
        ABT_NONE     = 2'd0,
        ABT_PREFETCH = 2'd1,
        ABT_DATA     = 2'd2
    } abt_kind_e;

    localparam logic [4:0] MODE_ABORT = 5'b10111;
endpackage

// File: rtl/abt_pipe.sv
`timescale 1ns/1ps
// Slot tracking for decode, execute and the pending data-access response.
module abt_pipe #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic          fetch_iabort,
    input  logic          ex_mem_op,
    input  logic          ex_is_load,
    input  logic          ex_branch_taken,
    input  logic          mem_dabort,
    output logic          take_data,
    output logic          take_pref,
    output logic          ex_live,
    output logic          ex_tagged,
    output logic [AW-1:0] ex_pc,
    output logic [AW-1:0] mem_pc,
    output logic          mem_load
);
    typedef struct packed {
        logic          dv;
        logic [AW-1:0] dpc;
        logic          dtag;
        logic          ev;
        logic [AW-1:0] epc;
        logic          etag;
        logic          mv;
        logic [AW-1:0] mpc;
        logic          mld;
    } pipe_st_t;

    pipe_st_t st_q, st_d;
    logic     kill_young;

    always_comb begin
        st_d       = st_q;
        take_data  = st_q.mv & mem_dabort;
        take_pref  = ~take_data & st_q.ev & st_q.etag;
        ex_live    = st_q.ev & ~st_q.etag & ~take_data;
        kill_young = take_data | take_pref | (ex_live & ex_branch_taken);

        st_d.mv  = ex_live & ex_mem_op;
        st_d.mpc = st_q.epc;
        st_d.mld = ex_is_load;

        st_d.ev   = st_q.dv & ~kill_young;
        st_d.epc  = st_q.dpc;
        st_d.etag = st_q.dtag;

        st_d.dv   = fetch_valid & ~kill_young;
        st_d.dpc  = fetch_pc;
        st_d.dtag = fetch_iabort;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_tagged = st_q.ev & st_q.etag;
    assign ex_pc     = st_q.epc;
    assign mem_pc    = st_q.mpc;
    assign mem_load  = st_q.mld;
endmodule

// File: rtl/abt_entry.sv
`timescale 1ns/1ps
// Exception entry values: vector, return address, saved and new status.
module abt_entry #(
    parameter int          AW       = 32,
    parameter int          SW       = 8,
    parameter int          IBIT     = 7,
    parameter logic [AW-1:0] VEC_PREF = 'h0C,
    parameter logic [AW-1:0] VEC_DATA = 'h10
) (
    input  logic          take_data,
    input  logic          take_pref,
    input  logic [AW-1:0] ex_pc,
    input  logic [AW-1:0] mem_pc,
    input  logic [SW-1:0] status_in,
    output logic [1:0]    exc_kind,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic [AW-1:0] lr_abt,
    output logic [SW-1:0] spsr_abt,
    output logic [SW-1:0] status_next
);
    import abt_pkg::*;

    localparam logic [AW-1:0] OFF_PREF = AW'(4);
    localparam logic [AW-1:0] OFF_DATA = AW'(8);

    abt_kind_e kind;

    always_comb begin
        kind           = ABT_NONE;
        redirect_pc    = '0;
        lr_abt         = '0;
        status_next    = status_in;
        if (take_data) begin
            kind        = ABT_DATA;
            redirect_pc = VEC_DATA;
            lr_abt      = mem_pc + OFF_DATA;
        end else if (take_pref) begin
            kind        = ABT_PREFETCH;
            redirect_pc = VEC_PREF;
            lr_abt      = ex_pc + OFF_PREF;
        end
        if (kind != ABT_NONE) begin
            status_next[4:0]  = MODE_ABORT;
            status_next[IBIT] = 1'b1;
        end
        exc_kind       = kind;
        redirect_valid = (kind != ABT_NONE);
        spsr_abt       = status_in;
    end
endmodule

// File: rtl/abt_ctrl.sv
`timescale 1ns/1ps
module abt_ctrl #(
    parameter int            AW       = 32,
    parameter int            SW       = 8,
    parameter int            IBIT     = 7,
    parameter logic [AW-1:0] VEC_PREF = 'h0C,
    parameter logic [AW-1:0] VEC_DATA = 'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic          fetch_iabort,
    input  logic          ex_mem_op,
    input  logic          ex_is_load,
    input  logic          ex_branch_taken,
    input  logic          mem_dabort,
    input  logic [SW-1:0] status_in,
    output logic          ex_live,
    output logic [AW-1:0] ex_pc,
    output logic [1:0]    exc_kind,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic [AW-1:0] lr_abt,
    output logic [SW-1:0] spsr_abt,
    output logic [SW-1:0] status_next,
    output logic          base_wb_cancel,
    output logic          load_we_cancel
);
    logic          take_data, take_pref, ex_tagged, mem_load;
    logic [AW-1:0] mem_pc;

    abt_pipe #(.AW(AW)) u_pipe (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_pc       (fetch_pc),
        .fetch_iabort   (fetch_iabort),
        .ex_mem_op      (ex_mem_op),
        .ex_is_load     (ex_is_load),
        .ex_branch_taken(ex_branch_taken),
        .mem_dabort     (mem_dabort),
        .take_data      (take_data),
        .take_pref      (take_pref),
        .ex_live        (ex_live),
        .ex_tagged      (ex_tagged),
        .ex_pc          (ex_pc),
        .mem_pc         (mem_pc),
        .mem_load       (mem_load)
    );

    abt_entry #(
        .AW(AW), .SW(SW), .IBIT(IBIT), .VEC_PREF(VEC_PREF), .VEC_DATA(VEC_DATA)
    ) u_entry (
        .take_data     (take_data),
        .take_pref     (take_pref),
        .ex_pc         (ex_pc),
        .mem_pc        (mem_pc),
        .status_in     (status_in),
        .exc_kind      (exc_kind),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc),
        .lr_abt        (lr_abt),
        .spsr_abt      (spsr_abt),
        .status_next   (status_next)
    );

    assign base_wb_cancel = take_data;
    assign load_we_cancel = take_data & mem_load;
endmodule

// File: rtl/abt_ctrl_chk.sv
`timescale 1ns/1ps
module abt_ctrl_chk #(
    parameter int AW   = 32,
    parameter int SW   = 8,
    parameter int IBIT = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic          fetch_iabort,
    input logic          ex_mem_op,
    input logic          ex_live,
    input logic          ex_tagged,
    input logic [AW-1:0] ex_pc,
    input logic [1:0]    exc_kind,
    input logic          redirect_valid,
    input logic [AW-1:0] lr_abt,
    input logic [SW-1:0] status_next,
    input logic          base_wb_cancel
);
    assert_pref_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 2'd1) |-> $past(fetch_valid && fetch_iabort, 2));

    assert_tag_not_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_tagged |-> !ex_live);

    assert_cancel_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_cancel |-> (exc_kind == 2'd2) && $past(ex_live && ex_mem_op));

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !ex_live && !ex_tagged);

    assert_lr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 2'd2) |-> lr_abt == $past(ex_pc) + AW'(8));

    assert_lr_pref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 2'd1) |-> lr_abt == ex_pc + AW'(4));

    assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> status_next[IBIT] && status_next[4:0] == 5'b10111);
endmodule

bind abt_ctrl abt_ctrl_chk #(.AW(AW), .SW(SW), .IBIT(IBIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_iabort  (fetch_iabort),
    .ex_mem_op     (ex_mem_op),
    .ex_live       (ex_live),
    .ex_tagged     (ex_tagged),
    .ex_pc         (ex_pc),
    .exc_kind      (exc_kind),
    .redirect_valid(redirect_valid),
    .lr_abt        (lr_abt),
    .status_next   (status_next),
    .base_wb_cancel(base_wb_cancel)
);

// File: tb/tb_abt_ctrl.sv
`timescale 1ns/1ps
module tb_abt_ctrl;
    localparam int AW = 32;
    localparam int SW = 8;
    localparam int IB = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_valid, fetch_iabort, ex_mem_op, ex_is_load, ex_branch_taken, mem_dabort;
    logic [AW-1:0] fetch_pc;
    logic [SW-1:0] status_in;
    logic          ex_live, redirect_valid, base_wb_cancel, load_we_cancel;
    logic [AW-1:0] ex_pc, redirect_pc, lr_abt;
    logic [1:0]    exc_kind;
    logic [SW-1:0] spsr_abt, status_next;

    abt_ctrl #(.AW(AW), .SW(SW), .IBIT(IB)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_iabort(fetch_iabort), .ex_mem_op(ex_mem_op), .ex_is_load(ex_is_load),
        .ex_branch_taken(ex_branch_taken), .mem_dabort(mem_dabort), .status_in(status_in),
        .ex_live(ex_live), .ex_pc(ex_pc), .exc_kind(exc_kind), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .lr_abt(lr_abt), .spsr_abt(spsr_abt),
        .status_next(status_next), .base_wb_cancel(base_wb_cancel), .load_we_cancel(load_we_cancel)
    );

    always #2.5 clk = ~clk;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    // Reference slots
    logic          r_dv, r_dtag, r_ev, r_etag, r_mv, r_mld;
    logic [AW-1:0] r_dpc, r_epc, r_mpc;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] entry_status(input logic [SW-1:0] s);
        logic [SW-1:0] r = s;
        r[4:0] = 5'b10111;
        r[IB]  = 1'b1;
        return r;
    endfunction

    task automatic step(input bit fv, input logic [AW-1:0] fpc, input bit fab,
                        input bit mem, input bit ld, input bit br, input bit dab,
                        input logic [SW-1:0] st);
        bit tk_d, tk_p, live, kill;
        logic [1:0] kind;
        string ktag;
        fetch_valid = fv; fetch_pc = fpc; fetch_iabort = fab; ex_mem_op = mem;
        ex_is_load = ld; ex_branch_taken = br; mem_dabort = dab; status_in = st;
        #1;
        tk_d = r_mv && dab;
        tk_p = !tk_d && r_ev && r_etag;
        live = r_ev && !r_etag && !tk_d;
        kill = tk_d || tk_p || (live && br);
        kind = tk_d ? 2'd2 : (tk_p ? 2'd1 : 2'd0);
        if (tk_d && r_ev && r_etag) ktag = "R5";
        else if (tk_d) ktag = "R4";
        else if (tk_p) ktag = "R2";
        else ktag = "R9";
        chk(exc_kind == kind, ktag, "exc_kind", 64'(exc_kind), 64'(kind));
        chk(redirect_valid == (tk_d || tk_p), "R6", "redirect_valid",
            64'(redirect_valid), 64'(tk_d || tk_p));
        chk(base_wb_cancel == tk_d, "R4", "base_wb_cancel", 64'(base_wb_cancel), 64'(tk_d));
        chk(load_we_cancel == (tk_d && r_mld), "R4", "load_we_cancel",
            64'(load_we_cancel), 64'(tk_d && r_mld));
        chk(ex_live == live, "R3", "ex_live", 64'(ex_live), 64'(live));
        if (live) chk(ex_pc == r_epc, "R2", "ex_pc", 64'(ex_pc), 64'(r_epc));
        if (tk_d) begin
            chk(redirect_pc == AW'('h10), "R6", "vector", 64'(redirect_pc), 64'h10);
            chk(lr_abt == r_mpc + 8, "R7", "lr data", 64'(lr_abt), 64'(r_mpc + 8));
        end else if (tk_p) begin
            chk(redirect_pc == AW'('h0C), "R6", "vector", 64'(redirect_pc), 64'h0C);
            chk(lr_abt == r_epc + 4, "R7", "lr pref", 64'(lr_abt), 64'(r_epc + 4));
        end
        if (tk_d || tk_p) begin
            chk(spsr_abt == st, "R8", "spsr", 64'(spsr_abt), 64'(st));
            chk(status_next == entry_status(st), "R8", "status_next",
                64'(status_next), 64'(entry_status(st)));
        end
        @(posedge clk);
        r_mv  = live && mem;
        r_mpc = r_epc;
        r_mld = ld;
        r_ev   = r_dv && !kill;
        r_epc  = r_dpc;
        r_etag = r_dtag;
        r_dv   = fv && !kill;
        r_dpc  = fpc;
        r_dtag = fab;
        #0.5;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 8'h10);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        fetch_valid = 0; fetch_pc = '0; fetch_iabort = 0; ex_mem_op = 0;
        ex_is_load = 0; ex_branch_taken = 0; mem_dabort = 1; status_in = 8'hD3;
        {r_dv, r_dtag, r_ev, r_etag, r_mv, r_mld} = '0;
        r_dpc = '0; r_epc = '0; r_mpc = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet under reset, even with mem_dabort high
        chk(exc_kind == 2'd0 && !redirect_valid && !base_wb_cancel && !load_we_cancel && !ex_live,
            "R1", "reset outputs", 64'({exc_kind, redirect_valid, base_wb_cancel, load_we_cancel, ex_live}), 64'h0);
        rst_n = 1;
        mem_dabort = 0;
        @(posedge clk); #0.5;

        // R2: tagged fetch raises instruction abort in execute two cycles later
        step(1, 'h100, 1, 0, 0, 0, 0, 8'h10);
        step(1, 'h104, 0, 0, 0, 0, 0, 8'h10);
        step(1, 'h108, 0, 0, 0, 1, 0, 8'h13); // R3: branch ignored, R2 abort taken here
        idle(3);

        // R3: branch flushes the tagged slot in decode
        step(1, 'h1F0, 0, 0, 0, 0, 0, 8'h10);
        step(1, 'h1F4, 1, 0, 0, 0, 0, 8'h10);
        step(1, 'h1F8, 0, 0, 0, 1, 0, 8'h10);
        idle(3);

        // R4: data abort with no access pending is ignored
        step(1, 'h200, 0, 0, 0, 0, 1, 8'h10);
        step(1, 'h204, 0, 0, 0, 0, 1, 8'h10);
        step(1, 'h208, 0, 0, 0, 0, 1, 8'h10);
        idle(2);

        // R5: data abort wins over a tagged slot in execute
        step(1, 'h300, 0, 0, 0, 0, 0, 8'h1F);
        step(1, 'h304, 1, 0, 0, 0, 0, 8'h1F);
        step(1, 'h308, 0, 1, 1, 0, 0, 8'h1F);
        step(1, 'h30C, 0, 0, 0, 0, 1, 8'h1F);
        idle(3);

        // R4: store abort, base cancelled without load cancel
        step(1, 'h400, 0, 0, 0, 0, 0, 8'h00);
        step(1, 'h404, 0, 0, 0, 0, 0, 8'h00);
        step(1, 'h408, 0, 1, 0, 0, 0, 8'h00);
        step(1, 'h40C, 0, 0, 0, 0, 1, 8'h60);
        idle(3);

        // Random mix
        begin
            int unsigned seed_val;
            logic [AW-1:0] pc;
            seed_val = $urandom(32'h5EED);
            pc = 'h1000;
            for (int i = 0; i < 4000; i++) begin
                bit fv, fab, mem, ld, br, dab;
                fv  = ($urandom % 8) != 0;
                fab = ($urandom % 6) == 0;
                mem = ($urandom % 3) == 0;
                ld  = $urandom % 2;
                br  = ($urandom % 8) == 0;
                dab = ($urandom % 4) == 0;
                step(fv, pc, fab, mem, ld, br, dab, SW'($urandom));
                pc = pc + 4;
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule